// File: doc/BRIEF.md
# Timing-Code Video Stream Framer

This block converts a stream of 10-bit pixel samples, accompanied by a line-active flag, a frame-active flag and a field flag, into one serial video word stream. Each line carries embedded timing codes, and a receiver can recover line and field structure from those codes alone. At each pixel clock the block emits exactly one output word. That word is a timing-code word, a blanking fill word or a range-limited sample.

Every line is framed by two four-word codes. A start code occupies the four words just before the first sample of the line, and the incoming samples are delayed so that they follow the start code. An end code occupies the four words just after the last sample. Between lines, the block sends a constant fill value. On lines that the frame flag marks as outside the picture, the block sends the fill value where the samples would go, and it still sends both codes. A width mode input can restrict every word to an 8-bit significance by clearing its two lowest bits. A power-down input and the reset both force the fill value.

The upstream source must keep the line-active flag high for at least four cycles and low for at least eight cycles. It must hold the frame and field flags steady from eight cycles before a line starts until eight cycles after that line ends.

Top module: `stream_code_framer`

## Requirements
- R1: While `rst_n` is low, `vid_out` is 040h immediately, without waiting for a clock edge.
- R2: On the first clock edge that samples `line_ref` high, and on the three edges after it, `vid_out` becomes 3FFh, 000h, 000h and then the start status word, in that order.
- R3: The sample taken at edge n appears on `vid_out` at edge n+4, limited to the range 004h..3FBh: values below 004h give 004h, and values above 3FBh give 3FBh.
- R4: On the four edges after the last sample of a line is output, `vid_out` becomes 3FFh, 000h, 000h and then the end status word.
- R5: A status word has bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H, and bits 1:0 = 0. H is 0 in the start code and 1 in the end code.
- R6: F equals `field_even` (1 for the even field, 0 for the odd field). V is the inverse of `frame_ref` (1 on blanking lines).
- R7: On a line where `frame_ref` is low, both codes are still sent, but every sample position carries 040h.
- R8: Outside the two codes and the samples, `vid_out` is 040h, and `pix_in` has no effect there.
- R9: While `pwr_dn` is high at a clock edge, `vid_out` becomes 040h at that edge.
- R10: While `bits8_mode` is high at a clock edge, bits 1:0 of the word output at that edge are 0. This applies to codes, fill words and samples alike, so the first code word becomes 3FCh and the upper limit becomes 3F8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Forces the fill word while high |
| bits8_mode | input | 1 | Clears the two LSBs of every output word |
| line_ref | input | 1 | High during the active samples of a line |
| frame_ref | input | 1 | High on active picture lines |
| field_even | input | 1 | 1 = even field, 0 = odd field |
| pix_in | input | 10 | Incoming pixel sample |
| vid_out | output | 10 | Framed output word |

## Verification
Every output comes from a single output register. The start code therefore begins on the same edge that first samples `line_ref` high. A sample appears four edges after it is taken, and the end code begins four edges after `line_ref` is first sampled low. Power-down and the width mode act on the edge that samples them, while reset acts at once. The bench drives inputs at the falling edge and reads `vid_out` one nanosecond after each rising edge. It sets the expected word for that exact edge from the cycle's position inside the scripted line, so each check falls on the edge where its result is due. Each line starts and ends with at least ten idle cycles. This keeps any residue of the previous line out of the checked window.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;
   // Number of words in one timing code
   localparam int unsigned CODE_LEN = 4;
   // Significance of the reference 8-bit code grid
   localparam int unsigned REF_W    = 8;

   // Status byte on the 8-bit grid: marker, F, V, H, then four protection bits
   function automatic logic [REF_W-1:0] status_byte(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction
endpackage

// File: rtl/vfmt_delay.sv
module vfmt_delay #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] stage [DEPTH];

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("vfmt_delay: DEPTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) stage[i] <= '0;
      end else begin
         stage[0] <= d_in;
         for (int i = 1; i < int'(DEPTH); i++) stage[i] <= stage[i-1];
      end
   end

   assign d_out = stage[DEPTH-1];
endmodule

// File: rtl/vfmt_limit.sv
module vfmt_limit #(
   parameter int unsigned DATA_W = 10
) (
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] lim
);
   localparam int unsigned SH = DATA_W - vfmt_pkg::REF_W;
   localparam logic [DATA_W-1:0] LO_W = DATA_W'(1) << SH;
   localparam logic [DATA_W-1:0] HI_W = (DATA_W'(254) << SH) | DATA_W'((64'd1 << SH) - 64'd1);

   always_comb begin
      if (raw < LO_W)      lim = LO_W;
      else if (raw > HI_W) lim = HI_W;
      else                 lim = raw;
   end
endmodule

// File: rtl/vfmt_word_sel.sv
module vfmt_word_sel #(
   parameter int unsigned DATA_W = 10,
   parameter int unsigned CL     = vfmt_pkg::CODE_LEN
) (
   input  logic [2*CL:0]      hist,     // hist[0] = line flag now, hist[i] = i edges ago
   input  logic               f_new,
   input  logic               vb_new,   // blanking flag for the line about to start
   input  logic               f_old,
   input  logic               vb_old,   // blanking flag aligned with delayed samples
   input  logic [DATA_W-1:0]  pix_lim,
   output logic [DATA_W-1:0]  word
);
   localparam int unsigned TAPS  = 2 * CL;
   localparam int unsigned IDX_W = (CL > 1) ? $clog2(CL) : 1;
   localparam int unsigned SH    = DATA_W - vfmt_pkg::REF_W;
   localparam logic [DATA_W-1:0] BLANK_W = DATA_W'(16) << SH;

   logic [IDX_W-1:0] sav_idx;
   logic [IDX_W-1:0] eav_idx;
   logic             eav_on;

   function automatic logic [DATA_W-1:0] code_word(input logic [IDX_W-1:0] idx,
                                                    input logic f, input logic v, input logic h);
      if (idx == '0)                  return '1;
      else if (idx == IDX_W'(CL - 1)) return DATA_W'(vfmt_pkg::status_byte(f, v, h)) << SH;
      else                            return '0;
   endfunction

   always_comb begin
      sav_idx = '0;
      eav_idx = '0;
      eav_on  = |hist[TAPS:CL+1];
      for (int i = 1; i < int'(CL); i++) begin
         if (hist[i]) sav_idx = IDX_W'(i);
      end
      for (int j = int'(CL) - 1; j >= 0; j--) begin
         if (hist[int'(CL) + 1 + j]) eav_idx = IDX_W'(j);
      end
      if (hist[CL])      word = vb_old ? BLANK_W : pix_lim;
      else if (eav_on)   word = code_word(eav_idx, f_old, vb_old, 1'b1);
      else if (hist[0])  word = code_word(sav_idx, f_new, vb_new, 1'b0);
      else               word = BLANK_W;
   end
endmodule

// File: rtl/stream_code_framer.sv
module stream_code_framer #(
   parameter int unsigned DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic              bits8_mode,
   input  logic              line_ref,
   input  logic              frame_ref,
   input  logic              field_even,
   input  logic [DATA_W-1:0] pix_in,
   output logic [DATA_W-1:0] vid_out
);
   localparam int unsigned CL   = vfmt_pkg::CODE_LEN;
   localparam int unsigned TAPS = 2 * CL;
   localparam int unsigned SH   = DATA_W - vfmt_pkg::REF_W;
   localparam logic [DATA_W-1:0] BLANK_W = DATA_W'(16) << SH;
   localparam logic [DATA_W-1:0] NARROW_MASK = ~DATA_W'((64'd1 << SH) - 64'd1);

   generate
      if (DATA_W < vfmt_pkg::REF_W) begin : g_bad_width
         $error("stream_code_framer: DATA_W must be at least 8");
      end
      if (CL < 2) begin : g_bad_code
         $error("stream_code_framer: code length must be at least 2");
      end
   endgenerate

   // Line flag history, one single-stage register per tap
   logic [TAPS:0] hist;
   assign hist[0] = line_ref;

   generate
      for (genvar t = 1; t <= int'(TAPS); t++) begin : g_hist
         vfmt_delay #(.WIDTH(1), .DEPTH(1)) u_tap (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (hist[t-1]),
            .d_out (hist[t])
         );
      end
   endgenerate

   // Sample and line flags delayed to line up behind the start code
   logic [DATA_W+1:0] pdly;
   vfmt_delay #(.WIDTH(DATA_W + 2), .DEPTH(CL)) u_pix_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({field_even, frame_ref, pix_in}),
      .d_out (pdly)
   );

   logic [DATA_W-1:0] pix_lim;
   vfmt_limit #(.DATA_W(DATA_W)) u_lim (
      .raw (pdly[DATA_W-1:0]),
      .lim (pix_lim)
   );

   logic [DATA_W-1:0] word;
   vfmt_word_sel #(.DATA_W(DATA_W), .CL(CL)) u_sel (
      .hist    (hist),
      .f_new   (field_even),
      .vb_new  (~frame_ref),
      .f_old   (pdly[DATA_W+1]),
      .vb_old  (~pdly[DATA_W]),
      .pix_lim (pix_lim),
      .word    (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          vid_out <= BLANK_W;
      else if (pwr_dn)     vid_out <= BLANK_W;
      else if (bits8_mode) vid_out <= word & NARROW_MASK;
      else                 vid_out <= word;
   end
endmodule

// File: rtl/vfmt_checker.sv
module vfmt_checker #(
   parameter int unsigned DATA_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_dn,
   input logic              bits8_mode,
   input logic [DATA_W-1:0] vid_out
);
   localparam int unsigned SH = DATA_W - 8;
   localparam logic [DATA_W-1:0] FILL = DATA_W'(16) << SH;
   localparam logic [DATA_W-1:0] LO_V = DATA_W'(1) << SH;
   localparam logic [DATA_W-1:0] HI_V = (DATA_W'(254) << SH) | DATA_W'((64'd1 << SH) - 64'd1);

   // R9: power-down yields the fill word on the next registered output
   a_r9_pwr_fill: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> vid_out == FILL);

   // R2 / R4: an all-ones word is always followed by a zero word
   a_r2_code_order: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_out == {DATA_W{1'b1}} && !pwr_dn) |=> vid_out == '0);

   // R3: outside the code words every value stays inside the limited range
   a_r3_legal_range: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_out == '0) || (&vid_out[DATA_W-1:SH]) || (vid_out >= LO_V && vid_out <= HI_V));

   // R5: the fourth code word carries a consistent protection nibble
   a_r5_status_prot: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(vid_out, 3) == {DATA_W{1'b1}} && $past(vid_out, 2) == '0 &&
       $past(vid_out, 1) == '0 && !$past(pwr_dn)) |->
      (vid_out[DATA_W-1] &&
       vid_out[SH+3] == (vid_out[SH+5] ^ vid_out[SH+4]) &&
       vid_out[SH+2] == (vid_out[SH+6] ^ vid_out[SH+4]) &&
       vid_out[SH+1] == (vid_out[SH+6] ^ vid_out[SH+5]) &&
       vid_out[SH]   == (vid_out[SH+6] ^ vid_out[SH+5] ^ vid_out[SH+4])));

   // R10: narrow mode clears the two LSBs of the next word
   a_r10_narrow_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      bits8_mode |=> vid_out[1:0] == 2'b00);
endmodule

bind stream_code_framer vfmt_checker #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_dn     (pwr_dn),
   .bits8_mode (bits8_mode),
   .vid_out    (vid_out)
);

// File: tb/stream_code_framer_test.sv
module stream_code_framer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_dn = 1'b0;
   logic       bits8_mode = 1'b0;
   logic       line_ref = 1'b0;
   logic       frame_ref = 1'b0;
   logic       field_even = 1'b0;
   logic [9:0] pix_in = 10'h155;
   logic [9:0] vid_out;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   localparam int LEAD = 10;
   localparam int TRAIL = 12;

   always #2 clk = ~clk;

   stream_code_framer uut (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .bits8_mode(bits8_mode),
      .line_ref(line_ref), .frame_ref(frame_ref), .field_even(field_even),
      .pix_in(pix_in), .vid_out(vid_out)
   );

   task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: vid_out=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [9:0] pix_fn(input int k, input int seed);
      case (k)
         0: return 10'h000;
         1: return 10'h3FF;
         2: return 10'h004;
         3: return 10'h3FB;
         4: return 10'h003;
         5: return 10'h3FC;
         default: return 10'((k * 37 + seed) & 10'h3FF);
      endcase
   endfunction

   function automatic logic [9:0] limit(input logic [9:0] v);
      if (v < 10'h004) return 10'h004;
      if (v > 10'h3FB) return 10'h3FB;
      return v;
   endfunction

   // R5 status layout computed from the requirement
   function automatic logic [9:0] status(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
   endfunction

   // Drive one scripted line and check every output edge of it
   task automatic run_line(input logic f, input logic act_line, input logic pd,
                           input logic m8, input int alen, input int seed);
      logic vb = ~act_line;
      for (int c = 0; c < LEAD + alen + TRAIL; c++) begin
         logic [9:0] exp;
         string tag;
         int k;
         @(negedge clk);
         field_even = f;
         frame_ref  = act_line;
         pwr_dn     = pd;
         bits8_mode = m8;
         line_ref   = (c >= LEAD && c < LEAD + alen);
         pix_in     = line_ref ? pix_fn(c - LEAD, seed) : 10'((c * 91 + 7) & 10'h3FF);
         @(posedge clk);
         #1;
         k = c - LEAD;
         if (k >= 0 && k < 3) begin
            exp = (k == 0) ? 10'h3FF : 10'h000;
            tag = "R2";
         end else if (k == 3) begin
            exp = status(f, vb, 1'b0);
            tag = "R2,R5,R6";
         end else if (k >= 4 && k < 4 + alen) begin
            exp = vb ? 10'h040 : limit(pix_fn(k - 4, seed));
            tag = vb ? "R7" : "R3";
         end else if (k >= 4 + alen && k < 7 + alen) begin
            exp = (k == 4 + alen) ? 10'h3FF : 10'h000;
            tag = "R4";
         end else if (k == 7 + alen) begin
            exp = status(f, vb, 1'b1);
            tag = "R4,R5,R6";
         end else begin
            exp = 10'h040;
            tag = "R8";
         end
         if (m8) begin
            exp = exp & 10'h3FC;
            tag = "R10";
         end
         if (pd) begin
            exp = 10'h040;
            tag = "R9";
         end
         check(tag, vid_out, exp);
      end
   endtask

   task automatic reset_start();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", vid_out, 10'h040);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R8", vid_out, 10'h040);
   endtask

   task automatic reset_midline();
      @(negedge clk);
      frame_ref = 1'b1;
      field_even = 1'b0;
      line_ref = 1'b1;
      for (int i = 0; i < 7; i++) begin
         pix_in = 10'h2A0;
         @(negedge clk);
      end
      #0.5;
      check("R3", vid_out, 10'h2A0);
      rst_n = 1'b0;
      #0.5;
      check("R1", vid_out, 10'h040);
      line_ref = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (12) @(negedge clk);
      check("R1", vid_out, 10'h040);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      finish_run();
   end

   initial begin
      reset_start();
      run_line(1'b0, 1'b1, 1'b0, 1'b0, 16, 3);   // odd field, active line
      run_line(1'b1, 1'b1, 1'b0, 1'b0, 9, 11);   // even field, active line
      run_line(1'b1, 1'b0, 1'b0, 1'b0, 12, 5);   // vertical blanking line
      run_line(1'b0, 1'b0, 1'b0, 1'b0, 6, 2);    // odd field blanking line
      run_line(1'b0, 1'b1, 1'b0, 1'b1, 10, 21);  // narrow mode
      run_line(1'b1, 1'b1, 1'b1, 1'b0, 8, 9);    // power-down
      run_line(1'b0, 1'b1, 1'b0, 1'b0, 4, 13);   // shortest line after power-down
      reset_midline();
      run_line(1'b1, 1'b1, 1'b0, 1'b0, 7, 17);   // recovery after reset
      finish_run();
   end
endmodule